// File: doc/BRIEF.md
# Single-Cycle Subset RISC Core

This block is a 32-bit processor core that completes one instruction per clock. It supports a small integer subset of a classic three-operand RISC instruction set:

- register-format add, sub, and, or and signed set-less-than;
- word load and word store with a base-plus-offset address;
- branch-if-equal;
- an absolute jump within the current 256 MiB region.

Program text sits in an internal read-only instruction array. Data sits in an internal word-addressed array. Both are sized by parameters.

The control has two levels. A main decoder turns the 6-bit opcode into datapath steering and a 2-bit ALU class. A second decoder combines that class with the function field to produce a 4-bit ALU operation code.

A debug write port lets the surrounding logic seed the register file, typically while reset is held. The current program counter and every register-file writeback are visible on output ports, so execution can be followed from outside without probing internal state.

Top module: `sc_core`

## Requirements
- R1: Each instruction completes in one clock. When an instruction is neither a jump nor a taken branch, the PC after the next rising edge is the old PC plus 4. PC, register file and data array change only on the rising edge.
- R2: The ALU operation code is 4 bits: AND=0000, OR=0001, ADD=0010, SUB=0110, SLT=0111, NOR=1100. The ALU class is 00 for load and store, which forces ADD. It is 01 for beq, which forces SUB. It is 10 for register format, where the function field picks the operation.
- R3: Register-format instructions (opcode 0x00) use these function codes: add 0x20, sub 0x22, and 0x24, or 0x25. Each writes rs op rt into the register named by bits 15:11.
- R4: slt (function 0x2A) writes 1 when rs is less than rt as signed 32-bit values, and 0 otherwise.
- R5: lw (0x23) and sw (0x2B) use address rs plus the sign-extended bits 15:0. lw writes the word at that address into the register named by bits 20:16. sw stores the register named by bits 20:16 and writes no register.
- R6: beq (0x04) compares rs with rt. When they are equal, the next PC is PC+4 plus the sign-extended offset shifted left by 2. When they differ, the next PC is PC+4.
- R7: j (0x02) sets the next PC to {bits 31:28 of PC+4, instruction bits 25:0, 2'b00}.
- R8: Register 0 always reads as zero. A write aimed at register 0 leaves it unchanged and raises no writeback indication.
- R9: While the synchronous active-high reset is asserted, the PC is 0 and no register writeback is indicated.
- R10: An opcode outside the supported set writes no register and no memory, and the PC advances by 4.
- R11: The ALU zero flag is high exactly when its result is all zeros. beq uses this flag as its equality test.
- R12: When the debug write enable is high, the debug value is written into the debug-selected register at the rising edge. This write takes priority over any core write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| dbg_wr_en | input | 1 | Debug register write enable |
| dbg_wr_idx | input | 5 | Debug register write index |
| dbg_wr_val | input | 32 | Debug register write value |
| pc_o | output | 32 | PC of the instruction executing this cycle |
| wb_en_o | output | 1 | A core register writeback happens at the next edge |
| wb_idx_o | output | 5 | Destination register of that writeback |
| wb_val_o | output | 32 | Value being written back |

## Verification
The bench builds the core with a 32-word instruction array and a 16-word data array. The program and its branch and jump targets fit in that space. The data index then comes from address bits 5:2, so a store at a positive offset and a load at a negative offset both land on known words.

A store is checked by loading the same word back through the writeback port. A register-0 write is checked by reading register 0 as a source in a later instruction. The program ends in a branch to itself, so the bench can confirm that the PC stays fixed on that instruction.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int XLEN = 32;
    localparam int NREG = 32;
    localparam int RIDX = 5;

    localparam logic [5:0] OPC_REG  = 6'h00;
    localparam logic [5:0] OPC_JMP  = 6'h02;
    localparam logic [5:0] OPC_BEQ  = 6'h04;
    localparam logic [5:0] OPC_LOAD = 6'h23;
    localparam logic [5:0] OPC_STOR = 6'h2B;

    typedef enum logic [1:0] {
        CLS_MEM   = 2'b00,
        CLS_BR    = 2'b01,
        CLS_FUNCT = 2'b10
    } alu_cls_e;

    localparam logic [3:0] ALU_AND = 4'b0000;
    localparam logic [3:0] ALU_OR  = 4'b0001;
    localparam logic [3:0] ALU_ADD = 4'b0010;
    localparam logic [3:0] ALU_SUB = 4'b0110;
    localparam logic [3:0] ALU_SLT = 4'b0111;
    localparam logic [3:0] ALU_NOR = 4'b1100;

    typedef struct packed {
        logic     dst_from_rd;
        logic     b_from_imm;
        logic     wb_from_mem;
        logic     reg_wr;
        logic     mem_wr;
        logic     is_branch;
        logic     is_jump;
        alu_cls_e alu_cls;
    } ctrl_t;

    typedef struct packed {
        logic [5:0]      opcode;
        logic [RIDX-1:0] rs;
        logic [RIDX-1:0] rt;
        logic [RIDX-1:0] rd;
        logic [4:0]      shamt;
        logic [5:0]      funct;
    } instr_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

    function automatic logic is_known_op(input logic [5:0] op);
        return (op == OPC_REG) || (op == OPC_JMP) || (op == OPC_BEQ) ||
               (op == OPC_LOAD) || (op == OPC_STOR);
    endfunction

endpackage

// File: rtl/sc_main_dec.sv
module sc_main_dec
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl = '{dst_from_rd: 1'b0, b_from_imm: 1'b0, wb_from_mem: 1'b0,
                 reg_wr: 1'b0, mem_wr: 1'b0, is_branch: 1'b0,
                 is_jump: 1'b0, alu_cls: CLS_MEM};
        case (opcode)
            OPC_REG: begin
                ctrl.dst_from_rd = 1'b1;
                ctrl.reg_wr      = 1'b1;
                ctrl.alu_cls     = CLS_FUNCT;
            end
            OPC_LOAD: begin
                ctrl.b_from_imm  = 1'b1;
                ctrl.wb_from_mem = 1'b1;
                ctrl.reg_wr      = 1'b1;
            end
            OPC_STOR: begin
                ctrl.b_from_imm = 1'b1;
                ctrl.mem_wr     = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.is_branch = 1'b1;
                ctrl.alu_cls   = CLS_BR;
            end
            OPC_JMP: ctrl.is_jump = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/sc_alu_ctl.sv
module sc_alu_ctl
    import sc_pkg::*;
(
    input  alu_cls_e   alu_cls,
    input  logic [5:0] funct,
    output logic [3:0] alu_code
);
    logic a1, a0;
    assign a1 = alu_cls[1];
    assign a0 = alu_cls[0];

    logic unused_funct;
    assign unused_funct = ^{funct[5:4]};

    always_comb begin
        alu_code[3] = 1'b0;
        alu_code[2] = a0 | (a1 & funct[1]);
        alu_code[1] = ~a1 | ~funct[2];
        alu_code[0] = a1 & (funct[3] | funct[0]);
    end

    always_comb begin
        if (alu_cls == CLS_MEM)
            AST_MEM_CLASS_ADD: assert (alu_code == ALU_ADD); // R2
        if (alu_cls == CLS_BR)
            AST_BR_CLASS_SUB: assert (alu_code == ALU_SUB); // R2
    end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
(
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    input  logic [3:0]      alu_code,
    output logic [XLEN-1:0] result,
    output logic            zero
);
    logic [XLEN-1:0] diff;
    assign diff = op_a - op_b;

    always_comb begin
        case (alu_code)
            ALU_AND: result = op_a & op_b;
            ALU_OR:  result = op_a | op_b;
            ALU_ADD: result = op_a + op_b;
            ALU_SUB: result = diff;
            ALU_SLT: result = {{(XLEN-1){1'b0}}, ($signed(op_a) < $signed(op_b))};
            ALU_NOR: result = ~(op_a | op_b);
            default: result = '0;
        endcase
    end

    assign zero = (result == '0);

    always_comb begin
        if (alu_code == ALU_SLT)
            AST_SLT_IS_BOOL: assert (result[XLEN-1:1] == '0); // R4
    end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
    import sc_pkg::*;
(
    input  logic            clk,
    input  logic            core_we,
    input  logic [RIDX-1:0] core_idx,
    input  logic [XLEN-1:0] core_val,
    input  logic            dbg_we,
    input  logic [RIDX-1:0] dbg_idx,
    input  logic [XLEN-1:0] dbg_val,
    input  logic [RIDX-1:0] rd_idx_a,
    input  logic [RIDX-1:0] rd_idx_b,
    output logic [XLEN-1:0] rd_val_a,
    output logic [XLEN-1:0] rd_val_b
);
    logic [XLEN-1:0] regs [NREG];

    logic            wr_go;
    logic [RIDX-1:0] wr_idx;
    logic [XLEN-1:0] wr_val;

    always_comb begin
        wr_go  = 1'b0;
        wr_idx = core_idx;
        wr_val = core_val;
        if (dbg_we) begin
            wr_go  = 1'b1;
            wr_idx = dbg_idx;
            wr_val = dbg_val;
        end else if (core_we) begin
            wr_go = 1'b1;
        end
    end

    generate
        for (genvar g = 1; g < NREG; g++) begin : g_reg
            always_ff @(posedge clk) begin
                if (wr_go && (wr_idx == RIDX'(g)))
                    regs[g] <= wr_val;
            end
        end
    endgenerate

    always_ff @(posedge clk) regs[0] <= '0;

    assign rd_val_a = (rd_idx_a == '0) ? '0 : regs[rd_idx_a];
    assign rd_val_b = (rd_idx_b == '0) ? '0 : regs[rd_idx_b];
endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        dbg_wr_en,
    input  logic [4:0]  dbg_wr_idx,
    input  logic [31:0] dbg_wr_val,
    output logic [31:0] pc_o,
    output logic        wb_en_o,
    output logic [4:0]  wb_idx_o,
    output logic [31:0] wb_val_o
);
    localparam int IAW = $clog2(IMEM_WORDS);
    localparam int DAW = $clog2(DMEM_WORDS);

    logic [XLEN-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];

    initial begin
        for (int k = 0; k < IMEM_WORDS; k++) imem[k] = '0;
    end

    logic [XLEN-1:0] pc_q, pc_nxt, pc_plus4, br_tgt, jmp_tgt;
    logic [XLEN-1:0] instr_w;
    instr_t          ins;
    ctrl_t           ctrl;
    logic [3:0]      alu_code;
    logic [XLEN-1:0] rs_val, rt_val, alu_b, alu_res, imm_ext, mem_rdata, wb_val;
    logic            alu_zero, rf_we, br_taken;
    logic [RIDX-1:0] dst_idx;
    logic [DAW-1:0]  dmem_idx;

    assign instr_w = imem[pc_q[IAW+1:2]];
    assign ins     = instr_t'(instr_w);
    assign imm_ext = sext16(instr_w[15:0]);

    sc_main_dec u_dec (
        .opcode (ins.opcode),
        .ctrl   (ctrl)
    );

    sc_alu_ctl u_actl (
        .alu_cls  (ctrl.alu_cls),
        .funct    (ins.funct),
        .alu_code (alu_code)
    );

    sc_regfile u_rf (
        .clk      (clk),
        .core_we  (rf_we),
        .core_idx (dst_idx),
        .core_val (wb_val),
        .dbg_we   (dbg_wr_en),
        .dbg_idx  (dbg_wr_idx),
        .dbg_val  (dbg_wr_val),
        .rd_idx_a (ins.rs),
        .rd_idx_b (ins.rt),
        .rd_val_a (rs_val),
        .rd_val_b (rt_val)
    );

    assign alu_b = ctrl.b_from_imm ? imm_ext : rt_val;

    sc_alu u_alu (
        .op_a     (rs_val),
        .op_b     (alu_b),
        .alu_code (alu_code),
        .result   (alu_res),
        .zero     (alu_zero)
    );

    assign dmem_idx  = alu_res[DAW+1:2];
    assign mem_rdata = dmem[dmem_idx];

    always_ff @(posedge clk) begin
        if (!rst && ctrl.mem_wr)
            dmem[dmem_idx] <= rt_val;
    end

    assign dst_idx = ctrl.dst_from_rd ? ins.rd : ins.rt;
    assign wb_val  = ctrl.wb_from_mem ? mem_rdata : alu_res;
    assign rf_we   = ctrl.reg_wr && !rst;

    assign pc_plus4 = pc_q + 32'd4;
    assign br_tgt   = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
    assign jmp_tgt  = {pc_plus4[31:28], instr_w[25:0], 2'b00};
    assign br_taken = ctrl.is_branch && alu_zero;

    always_comb begin
        if (ctrl.is_jump)  pc_nxt = jmp_tgt;
        else if (br_taken) pc_nxt = br_tgt;
        else               pc_nxt = pc_plus4;
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_nxt;
    end

    assign pc_o     = pc_q;
    assign wb_en_o  = rf_we && (dst_idx != '0);
    assign wb_idx_o = dst_idx;
    assign wb_val_o = wb_val;

    logic unused_bits;
    assign unused_bits = ^{alu_res[XLEN-1:DAW+2], alu_res[1:0], ins.shamt,
                           imm_ext[XLEN-1:XLEN-2]};

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.is_jump && !br_taken) |=> (pc_q == $past(pc_q) + 32'd4)); // R1
    AST_BEQ_EQUAL: assert property (@(posedge clk) disable iff (rst)
        br_taken |-> (rs_val == rt_val)); // R6
    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
        ctrl.is_jump |=> (pc_q[27:0] == {$past(instr_w[25:0]), 2'b00})); // R7
    AST_UNKNOWN_QUIET: assert property (@(posedge clk) disable iff (rst)
        !is_known_op(ins.opcode) |-> (!ctrl.reg_wr && !ctrl.mem_wr && !ctrl.is_jump && !ctrl.is_branch)); // R10
endmodule

// File: tb/sc_core_tb_top.sv
module sc_core_tb_top;

    localparam int IMW = 32;
    localparam int DMW = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic        dbg_wr_en;
    logic [4:0]  dbg_wr_idx;
    logic [31:0] dbg_wr_val;
    logic [31:0] pc_o;
    logic        wb_en_o;
    logic [4:0]  wb_idx_o;
    logic [31:0] wb_val_o;

    always #4 clk = ~clk;

    sc_core #(.IMEM_WORDS(IMW), .DMEM_WORDS(DMW)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .dbg_wr_en  (dbg_wr_en),
        .dbg_wr_idx (dbg_wr_idx),
        .dbg_wr_val (dbg_wr_val),
        .pc_o       (pc_o),
        .wb_en_o    (wb_en_o),
        .wb_idx_o   (wb_idx_o),
        .wb_val_o   (wb_val_o)
    );

    typedef struct {
        logic [31:0] pc;
        bit          wb;
        logic [4:0]  idx;
        logic [31:0] val;
        string       req;
    } exp_t;

    exp_t sb[$];
    int   total = 0;
    int   bad   = 0;
    bit   done  = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] pc, input bit wb, input logic [4:0] idx,
                        input logic [31:0] val, input string req);
        exp_t e;
        e.pc = pc; e.wb = wb; e.idx = idx; e.val = val; e.req = req;
        sb.push_back(e);
    endtask

    function automatic logic [31:0] rt_op(input logic [4:0] rs, input logic [4:0] rt,
                                          input logic [4:0] rd, input logic [5:0] fn);
        return {6'h00, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] it_op(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    task automatic dbg_load(input logic [4:0] idx, input logic [31:0] val);
        @(negedge clk);
        dbg_wr_en  = 1'b1;
        dbg_wr_idx = idx;
        dbg_wr_val = val;
        @(negedge clk);
        dbg_wr_en  = 1'b0;
    endtask

    initial begin
        rst        = 1'b1;
        dbg_wr_en  = 1'b0;
        dbg_wr_idx = '0;
        dbg_wr_val = '0;
        #1;
        for (int k = 0; k < IMW; k++) dut_i.imem[k] = 32'h0;
        dut_i.imem[0]  = rt_op(5'd1, 5'd2, 5'd7,  6'h20);          // add r7
        dut_i.imem[1]  = rt_op(5'd2, 5'd1, 5'd8,  6'h22);          // sub r8
        dut_i.imem[2]  = rt_op(5'd4, 5'd5, 5'd9,  6'h24);          // and r9
        dut_i.imem[3]  = rt_op(5'd4, 5'd5, 5'd10, 6'h25);          // or r10
        dut_i.imem[4]  = rt_op(5'd3, 5'd1, 5'd11, 6'h2A);          // slt r11
        dut_i.imem[5]  = rt_op(5'd1, 5'd3, 5'd12, 6'h2A);          // slt r12
        dut_i.imem[6]  = it_op(6'h2B, 5'd6, 5'd7,  16'd4);         // sw r7,4(r6)
        dut_i.imem[7]  = it_op(6'h23, 5'd6, 5'd13, 16'd4);         // lw r13,4(r6)
        dut_i.imem[8]  = it_op(6'h2B, 5'd6, 5'd1,  16'hFFF8);      // sw r1,-8(r6)
        dut_i.imem[9]  = it_op(6'h23, 5'd6, 5'd14, 16'hFFF8);      // lw r14,-8(r6)
        dut_i.imem[10] = rt_op(5'd1, 5'd1, 5'd0,  6'h20);          // add r0
        dut_i.imem[11] = rt_op(5'd0, 5'd1, 5'd15, 6'h20);          // add r15,r0,r1
        dut_i.imem[12] = it_op(6'h04, 5'd1, 5'd2, 16'd5);          // beq not taken
        dut_i.imem[13] = it_op(6'h04, 5'd7, 5'd6, 16'd2);          // beq taken
        dut_i.imem[14] = rt_op(5'd1, 5'd1, 5'd16, 6'h20);
        dut_i.imem[15] = rt_op(5'd1, 5'd1, 5'd16, 6'h20);
        dut_i.imem[16] = 32'hFC00_0000;                            // unknown opcode
        dut_i.imem[17] = {6'h02, 26'd20};                          // j word 20
        dut_i.imem[18] = rt_op(5'd1, 5'd1, 5'd17, 6'h20);
        dut_i.imem[19] = rt_op(5'd1, 5'd1, 5'd17, 6'h20);
        dut_i.imem[20] = it_op(6'h04, 5'd0, 5'd0, 16'hFFFF);       // beq to self

        dbg_load(5'd1, 32'd5);
        dbg_load(5'd2, 32'd3);
        dbg_load(5'd3, 32'hFFFF_FFFE);
        dbg_load(5'd4, 32'h0000_0F0F);
        dbg_load(5'd5, 32'h0000_00FF);
        dbg_load(5'd6, 32'd8);
        dbg_load(5'd0, 32'h0000_DEAD);

        #1;
        check(pc_o == 32'h0, "R9", "pc in reset", pc_o, 32'h0);
        check(wb_en_o == 1'b0, "R9", "wb_en in reset", {31'd0, wb_en_o}, 32'h0);

        push(32'd0,  1, 5'd7,  32'd8,          "R2/R3/R12");
        push(32'd4,  1, 5'd8,  32'hFFFF_FFFE,  "R2/R3");
        push(32'd8,  1, 5'd9,  32'h0000_000F,  "R3");
        push(32'd12, 1, 5'd10, 32'h0000_0FFF,  "R3");
        push(32'd16, 1, 5'd11, 32'd1,          "R4");
        push(32'd20, 1, 5'd12, 32'd0,          "R4");
        push(32'd24, 0, 5'd0,  32'd0,          "R5");
        push(32'd28, 1, 5'd13, 32'd8,          "R5");
        push(32'd32, 0, 5'd0,  32'd0,          "R5");
        push(32'd36, 1, 5'd14, 32'd5,          "R5");
        push(32'd40, 0, 5'd0,  32'd0,          "R8");
        push(32'd44, 1, 5'd15, 32'd5,          "R8/R12");
        push(32'd48, 0, 5'd0,  32'd0,          "R1/R6");
        push(32'd52, 0, 5'd0,  32'd0,          "R1/R6");
        push(32'd64, 0, 5'd0,  32'd0,          "R6/R11/R10");
        push(32'd68, 0, 5'd0,  32'd0,          "R1/R10");
        push(32'd80, 0, 5'd0,  32'd0,          "R7");
        push(32'd80, 0, 5'd0,  32'd0,          "R6/R11");
        push(32'd80, 0, 5'd0,  32'd0,          "R6/R11");

        @(negedge clk);
        rst = 1'b0;
        while (sb.size() > 0) begin
            exp_t e;
            #1;
            e = sb.pop_front();
            check(pc_o == e.pc, e.req, "pc", pc_o, e.pc);
            check(wb_en_o == e.wb, e.req, "wb_en", {31'd0, wb_en_o}, {31'd0, e.wb});
            if (e.wb && wb_en_o) begin
                check(wb_idx_o == e.idx, e.req, "wb_idx", {27'd0, wb_idx_o}, {27'd0, e.idx});
                check(wb_val_o == e.val, e.req, "wb_val", wb_val_o, e.val);
            end
            @(negedge clk);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog run did not finish actual=%0d expected=%0d", sb.size(), 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule